// File: doc/BRIEF.md
# Fuse Key Word Readout Controller

This block lets software fetch 32-bit words from a one-time-programmable security-ID fuse array through a small register bus. Software writes one control word. That word holds the fuse byte offset, an 8-bit unlock key and a read command bit. If the key is correct, the block starts a read of fixed length. The command bit stays set while the read runs and clears itself when the fetched word has landed in a read-only data register.

Software polls the command bit until it reads 0 and then reads the data register. It then writes zero to the control register to drop the lock. A full 256-byte key space is read as 64 word-aligned fetches at a stride of 4 bytes. The fuse array here is a behavioural model. It is a register array that is loaded at reset with a computed pattern.

Top module: `fuse_key_reader`

## Requirements
- R1: After reset, the control register (byte address 0x40) and the data register (byte address 0x60) both read as 0, and the command bit is 0.
- R2: The control register holds the fuse byte offset in bits 24:16, the key in bits 15:8 and the read command in bit 1. A control write while idle stores the offset and key fields, and all other bits read as 0.
- R3: A read starts only when a control write sets bit 1 with the value 0xAC in bits 15:8. Any other key leaves the command bit at 0 and leaves the data register unchanged.
- R4: Once a read is accepted, the command bit reads 1 for exactly LATENCY clock cycles (default 8) after the accepting edge, and then reads 0.
- R5: When the command bit clears, the data register holds the fuse word at index offset[7:2]. Offset bits 1:0 and bit 8 do not affect the word chosen.
- R6: Control writes made while the command bit is 1 are ignored. The stored fields, the word fetched and the timing are all unchanged.
- R7: The data register is read-only. A bus write to address 0x60 leaves its value unchanged.
- R8: Fuse word i (0 to 63) holds (i+1) * 0x9E3779B1, truncated to 32 bits.
- R9: Writing 0 to the control register returns it to 0 (idle). The data register keeps the last fetched word.
- R10: A read of any address other than 0x40 or 0x60, or a read with the read strobe low, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |

## Verification
An accepted control write takes effect at the clock edge that samples the strobe, so the command bit reads 1 straight after that edge. The bench reads it there and again after LATENCY-1 more edges, when it must still be 1. It then expects the bit to be 0 and the fetched word to be valid exactly one edge later. Rejected writes, ignored writes and data-register writes are checked right after their edge and again after a full read window. Every sample is taken 1 ns after a rising edge, with the read strobe driven only between edges.

// File: rtl/fkr_pkg.sv
package fkr_pkg;

    localparam int          WORD_W     = 32;
    localparam int          OFS_W      = 9;
    localparam int          KEY_W      = 8;
    localparam logic [7:0]  UNLOCK_KEY = 8'hAC;
    localparam logic [7:0]  CTRL_ADDR  = 8'h40;
    localparam logic [7:0]  DATA_ADDR  = 8'h60;
    localparam logic [31:0] FUSE_MULT  = 32'h9E3779B1;

    typedef struct packed {
        logic [OFS_W-1:0] offset;
        logic [KEY_W-1:0] key;
        logic             cmd;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.offset = w[24:16];
        c.key    = w[15:8];
        c.cmd    = w[1];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_pack(input ctrl_t c);
        return {7'b0, c.offset, c.key, 6'b0, c.cmd, 1'b0};
    endfunction

    function automatic logic [WORD_W-1:0] fuse_pattern(input int idx);
        logic [WORD_W-1:0] n;
        n = WORD_W'(idx + 1);
        return n * FUSE_MULT;
    endfunction

endpackage

// File: rtl/fkr_fuse_array.sv
module fkr_fuse_array
    import fkr_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                cells[i] <= fuse_pattern(i);
            end
        end
    end

    assign rd_word = cells[rd_idx];
endmodule

// File: rtl/fkr_read_seq.sv
module fkr_read_seq
    import fkr_pkg::*;
#(
    parameter int WORDS   = 64,
    parameter int LATENCY = 8,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int CNT_W  = $clog2(LATENCY) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    output logic [IDX_W-1:0]  fuse_idx,
    input  logic [WORD_W-1:0] fuse_word,
    output logic              busy,
    output logic [WORD_W-1:0] result
);
    logic [CNT_W-1:0] remain;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            idx_q  <= '0;
            result <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                remain <= CNT_W'(LATENCY - 1);
                idx_q  <= start_idx;
            end
        end else if (remain == '0) begin
            busy   <= 1'b0;
            result <= fuse_word;
        end else begin
            remain <= remain - 1'b1;
        end
    end

    assign fuse_idx = idx_q;
endmodule

// File: rtl/fkr_regbus.sv
module fkr_regbus
    import fkr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORDS  = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic [WORD_W-1:0] result,
    output logic              start,
    output logic [IDX_W-1:0]  start_idx,
    output logic [OFS_W-1:0]  off_q,
    output logic [KEY_W-1:0]  key_q
);
    ctrl_t wr_fields;
    ctrl_t view;
    logic  ctrl_hit;
    logic  data_hit;

    assign wr_fields = ctrl_unpack(bus_wdata);
    assign ctrl_hit  = (bus_addr == ADDR_W'(CTRL_ADDR));
    assign data_hit  = (bus_addr == ADDR_W'(DATA_ADDR));
    assign start     = bus_wr && ctrl_hit && !busy && wr_fields.cmd
                       && (wr_fields.key == UNLOCK_KEY);
    assign start_idx = wr_fields.offset[IDX_W+1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
            key_q <= '0;
        end else if (bus_wr && ctrl_hit && !busy) begin
            off_q <= wr_fields.offset;
            key_q <= wr_fields.key;
        end
    end

    always_comb begin
        view.offset = off_q;
        view.key    = key_q;
        view.cmd    = busy;
        bus_rdata   = '0;
        if (bus_rd) begin
            if (ctrl_hit)      bus_rdata = ctrl_pack(view);
            else if (data_hit) bus_rdata = result;
        end
    end
endmodule

// File: rtl/fuse_key_reader.sv
module fuse_key_reader
    import fkr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int WORDS   = 64,
    parameter int LATENCY = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int IDX_W = $clog2(WORDS);

    logic              seq_busy;
    logic              seq_start;
    logic [IDX_W-1:0]  seq_idx;
    logic [IDX_W-1:0]  arr_idx;
    logic [WORD_W-1:0] arr_word;
    logic [WORD_W-1:0] seq_word;
    logic [OFS_W-1:0]  reg_off;
    logic [KEY_W-1:0]  reg_key;

    fkr_regbus #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(seq_busy), .result(seq_word), .start(seq_start),
        .start_idx(seq_idx), .off_q(reg_off), .key_q(reg_key)
    );

    fkr_read_seq #(.WORDS(WORDS), .LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst(rst), .start(seq_start), .start_idx(seq_idx),
        .fuse_idx(arr_idx), .fuse_word(arr_word), .busy(seq_busy),
        .result(seq_word)
    );

    fkr_fuse_array #(.WORDS(WORDS)) u_fuse (
        .clk(clk), .rst(rst), .rd_idx(arr_idx), .rd_word(arr_word)
    );
endmodule

// File: rtl/fkr_checker.sv
module fkr_checker
    import fkr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LATENCY = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              busy,
    input logic [31:0]       data_word,
    input logic [OFS_W-1:0]  off_q,
    input logic [KEY_W-1:0]  key_q
);
    logic [15:0] hi_cycles;
    logic        ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    always_ff @(posedge clk) begin
        if (rst)       hi_cycles <= '0;
        else if (busy) hi_cycles <= hi_cycles + 1'b1;
        else           hi_cycles <= '0;
    end

    // R4: command bit never outlives the latency window
    a_r4_window_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (hi_cycles <= 16'(LATENCY - 1)));

    // R4: command bit clears only at the end of a full window
    a_r4_full_window: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(hi_cycles) == 16'(LATENCY - 1)));

    // R3: a wrong key never starts a read
    a_r3_bad_key: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !busy && (bus_wdata[15:8] != UNLOCK_KEY)) |=> !busy);

    // R5 / R7: data register changes only as the command bit clears
    a_r5_data_on_finish: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_word) |-> $fell(busy));

    // R6: control fields stay put while a read runs
    a_r6_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_wr && (hi_cycles < 16'(LATENCY - 1)))
        |=> ($stable(off_q) && $stable(key_q)));

    // R10: no read strobe, no data
    always_comb begin
        if (!rst && !bus_rd) begin
            a_r10_idle_bus: assert (bus_rdata == 32'h0);
        end
    end
endmodule

bind fuse_key_reader fkr_checker #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(seq_busy), .data_word(seq_word), .off_q(reg_off), .key_q(reg_key)
);

// File: tb/fuse_key_reader_test.sv
`timescale 1ns/1ps
module fuse_key_reader_test;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_data = '0;

    fuse_key_reader #(.ADDR_W(8), .WORDS(64), .LATENCY(LAT)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] fexp(input logic [8:0] ofs);
        logic [31:0] n;
        n = {26'b0, ofs[7:2]} + 32'd1;
        return n * 32'h9E3779B1;
    endfunction

    function automatic logic [31:0] ctrl_exp(input logic [8:0] ofs,
                                             input logic [7:0] key,
                                             input logic cmd);
        return {7'b0, ofs, key, 6'b0, cmd, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // accepted read: cmd high LAT cycles, then data valid (R4, R5)
    task automatic do_read(input logic [8:0] ofs);
        logic [31:0] v;
        wr(8'h40, ctrl_exp(ofs, 8'hAC, 1'b1) | 32'hFE0000FD);
        rd(8'h40, v); check("R2/R4 accept", v, ctrl_exp(ofs, 8'hAC, 1'b1));
        tick(LAT - 1);
        rd(8'h40, v); check("R4 still busy", v[1], 1'b1);
        tick(1);
        rd(8'h40, v); check("R4 cleared", v[1], 1'b0);
        exp_data = fexp(ofs);
        rd(8'h60, v); check("R5/R8 word", v, exp_data);
        wr(8'h40, 32'h0);
        rd(8'h40, v); check("R9 idle", v, 32'h0);
        rd(8'h60, v); check("R9 data kept", v, exp_data);
    endtask

    initial begin : watchdog
        #3000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [8:0]  ofs;
        logic [7:0]  key;
        void'($urandom(32'd20240611));
        tick(3);
        rst = 1'b0;
        tick(1);

        rd(8'h40, v); check("R1 ctrl reset", v, 32'h0);
        rd(8'h60, v); check("R1 data reset", v, 32'h0);

        // R2: idle field write readback
        wr(8'h40, 32'hFFA533FD);
        rd(8'h40, v); check("R2 fields", v, ctrl_exp(9'h1A5, 8'h33, 1'b0));
        wr(8'h40, 32'h0);

        // R10: unmapped address and no strobe
        rd(8'h44, v); check("R10 unmapped", v, 32'h0);
        check("R10 no strobe", bus_rdata, 32'h0);

        // R5 corners: low bits and bit 8 ignored, first and last word
        do_read(9'h000);
        do_read(9'h013);
        do_read(9'h010);
        do_read(9'h0FC);
        do_read(9'h1FF);

        // R3: wrong key
        wr(8'h40, ctrl_exp(9'h020, 8'hAD, 1'b1));
        rd(8'h40, v); check("R3 cmd clear", v[1], 1'b0);
        tick(LAT + 1);
        rd(8'h60, v); check("R3 data unchanged", v, exp_data);
        wr(8'h40, 32'h0);

        // R7: data register write
        wr(8'h60, 32'h12345678);
        rd(8'h60, v); check("R7 read-only", v, exp_data);

        // R6: writes while busy ignored
        wr(8'h40, ctrl_exp(9'h024, 8'hAC, 1'b1));
        tick(2);
        wr(8'h40, ctrl_exp(9'h0F0, 8'hAC, 1'b1));
        rd(8'h40, v); check("R6 fields kept", v, ctrl_exp(9'h024, 8'hAC, 1'b1));
        tick(LAT - 4);
        rd(8'h40, v); check("R6 timing busy", v[1], 1'b1);
        tick(1);
        rd(8'h40, v); check("R6 timing done", v[1], 1'b0);
        exp_data = fexp(9'h024);
        rd(8'h60, v); check("R6 word", v, exp_data);
        wr(8'h40, 32'h0);

        // random mix
        for (int n = 0; n < 40; n++) begin
            ofs = 9'($urandom);
            if (($urandom % 4) != 0) begin
                do_read(ofs);
            end else begin
                key = 8'($urandom);
                if (key == 8'hAC) key = 8'h00;
                wr(8'h40, ctrl_exp(ofs, key, 1'b1));
                rd(8'h40, v); check("R3 random key", v, ctrl_exp(ofs, key, 1'b0));
                tick(LAT);
                rd(8'h60, v); check("R3 random data", v, exp_data);
                wr(8'h40, 32'h0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule